// File: doc/BRIEF.md
# Dual-Master Bus Claim Sequencer

This block runs on the host side of a two-master selector that sits in front of a shared downstream bus. When software or a neighbouring controller asks for the bus, the sequencer reads the selector's control and status registers through a simple request/acknowledge register port. It decodes who owns the bus and whether the bus is switched on. It then writes a request, take-over or forced-reset command, waits a retry delay and tries again. It stops when the bus is held, when a hard deadline runs out, or when a read returns an error.

A soft deadline lets this master seize the bus from a partner that never lets go. A hard deadline, twice as long by default, ends the attempt. A release request switches the bus off, but only when this master holds it and the bus is on. Every delay and deadline is given in microseconds and converted to clock cycles through a clocks-per-microsecond parameter.

Top module: `bus_claim_seq`

## Requirements
- R1: Every operation starts by reading the control register (address CTL_ADDR, default 0x01). The status register (STAT_ADDR, default 0x02) is read only during an acquire, and only after the control value showed the bus off.
- R2: Control bits 0 and 1 form the ownership pair, and this master owns the bus when the two bits are equal. Bits 2 and 3 form the enable pair, and the bus is off when those two bits are equal.
- R3: When the bus is off and either status bit 7 (partner request) is clear or the soft deadline has passed, the sequencer writes TAB[ctl[3:0]] | 0x80 and retries after SHORT_US. TAB = {4,0,1,5,4,4,5,5,0,0,1,1,0,4,5,1}, indexed from 0.
- R4: When the bus is off, status bit 7 is set and the soft deadline has not passed, the sequencer writes nothing and retries after YIELD_US.
- R5: When the bus is on and owned, the acquire ends with result 0 (acquired). If control bit 7 or bit 4 is set, the value ctl & 0x6F is written first.
- R6: When the bus is on and owned by the partner before the soft deadline, the sequencer writes ctl | 0x80 only if bit 7 is clear, then retries after LONG_US.
- R7: When the bus is on and owned by the partner at or after the soft deadline (SOFT_US after the acquire is accepted), the sequencer writes TAB[ctl[3:0]] | 0x90 and retries after LONG_US.
- R8: After each retry delay, if HARD_US has elapsed since the acquire was accepted, the acquire ends with result 1 (timeout).
- R9: A release writes (ctl & 0x08) >> 1 when the bus is on and owned, and writes nothing otherwise. It ends with result 3 (released).
- R10: An error response to any read ends the operation at once with result 2 (error), with no further register access.
- R11: A request is accepted only while idle, and acquire wins when both are raised. busy is high from the cycle after acceptance until completion. done pulses for exactly one cycle, with busy low and result valid.
- R12: A register access holds reg_req, reg_addr, reg_we and reg_wdata steady until reg_ack is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acq_req | input | 1 | Start an acquire (sampled while idle) |
| rel_req | input | 1 | Start a release (sampled while idle) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 acquired, 1 timeout, 2 error, 3 released |
| reg_req | output | 1 | Register access request |
| reg_we | output | 1 | 1 write, 0 read |
| reg_addr | output | ADDR_W | Register address |
| reg_wdata | output | 8 | Write data |
| reg_ack | input | 1 | Access complete |
| reg_err | input | 1 | Error response on a read |
| reg_rdata | input | 8 | Read data, valid with reg_ack |

## Verification
busy rises one cycle after the edge that accepts a request and is compared against a bench-held expectation on every clock. done and result appear in the same cycle that busy falls, and each access must hold steady from one clock to the next until it is acknowledged. Forced take-overs and postponed takes must complete no earlier than the soft-deadline cycle count and within one retry delay plus handshake slack after it. A timeout must arrive between the hard-deadline count and that same slack beyond it. The modelled selector answers with a programmable latency, so every observation is taken at the falling edge after the handshake completes rather than at a fixed offset.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_CTL,
        ST_RD_STAT,
        ST_WR,
        ST_WAIT
    } state_e;

    typedef enum logic [1:0] {
        RES_ACQUIRED = 2'd0,
        RES_TIMEOUT  = 2'd1,
        RES_ERROR    = 2'd2,
        RES_RELEASED = 2'd3
    } result_e;

    typedef enum logic [1:0] {
        AFT_WAIT,
        AFT_ACQ,
        AFT_REL
    } after_e;

    typedef enum logic [1:0] {
        DLY_SHORT,
        DLY_LONG,
        DLY_YIELD
    } delay_e;

    // control register bit positions (decoded by the selector)
    localparam int unsigned C_OWN_A  = 0;
    localparam int unsigned C_OWN_B  = 1;
    localparam int unsigned C_EN_A   = 2;
    localparam int unsigned C_EN_B   = 3;
    localparam int unsigned C_RESET  = 4;
    localparam int unsigned C_CLAIM  = 7;
    // status register: partner has asked for the bus
    localparam int unsigned S_PEER_ASK = 7;

    // command that hands the bus to this master for a given low nibble
    function automatic logic [7:0] take_lookup(input logic [3:0] nib);
        logic [2:0] v;
        case (nib)
            4'h0, 4'h4, 4'h5, 4'hD: v = 3'd4;
            4'h1, 4'h8, 4'h9, 4'hC: v = 3'd0;
            4'h2, 4'hA, 4'hB, 4'hF: v = 3'd1;
            default:                v = 3'd5;
        endcase
        return {5'b0, v};
    endfunction

endpackage

// File: rtl/bcs_ctl_decode.sv
module bcs_ctl_decode
    import bcs_pkg::*;
(
    input  logic [7:0] ctl,
    output logic       bus_off,
    output logic       owned,
    output logic       dirty,
    output logic [7:0] take_cmd,
    output logic [7:0] force_cmd,
    output logic [7:0] claim_cmd,
    output logic [7:0] clean_cmd,
    output logic [7:0] off_cmd
);
    logic [7:0] base;

    always_comb begin
        base      = take_lookup(ctl[3:0]);
        owned     = (ctl[C_OWN_A] == ctl[C_OWN_B]);
        bus_off   = (ctl[C_EN_A] == ctl[C_EN_B]);
        dirty     = ctl[C_CLAIM] | ctl[C_RESET];
        take_cmd  = base | (8'd1 << C_CLAIM);
        force_cmd = base | (8'd1 << C_CLAIM) | (8'd1 << C_RESET);
        claim_cmd = ctl | (8'd1 << C_CLAIM);
        clean_cmd = ctl & ~((8'd1 << C_CLAIM) | (8'd1 << C_RESET));
        off_cmd   = {4'b0, ctl[C_EN_B], 3'b0} >> 1;
    end
endmodule

// File: rtl/bcs_deadline.sv
module bcs_deadline #(
    parameter int unsigned SOFT_CYC = 12500000,
    parameter int unsigned HARD_CYC = 25000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic soft_hit,
    output logic hard_hit
);
    localparam int unsigned CW = $clog2(HARD_CYC + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)
            cnt_d = '0;
        else if (cnt_q != CW'(HARD_CYC))
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign soft_hit = (cnt_q >= CW'(SOFT_CYC));
    assign hard_hit = (cnt_q == CW'(HARD_CYC));

    // a fresh acquire never sees an expired soft deadline
    assert_soft_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !soft_hit);
endmodule

// File: rtl/bcs_retry_timer.sv
module bcs_retry_timer #(
    parameter int unsigned MAX_CYC = 200000,
    localparam int unsigned TW     = $clog2(MAX_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/bus_claim_seq.sv
module bus_claim_seq
    import bcs_pkg::*;
#(
    parameter int unsigned CLK_PER_US = 100,
    parameter int unsigned SHORT_US   = 50,
    parameter int unsigned LONG_US    = 1000,
    parameter int unsigned YIELD_US   = 2000,
    parameter int unsigned SOFT_US    = 125000,
    parameter int unsigned HARD_US    = 250000,
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned CTL_ADDR   = 1,
    parameter int unsigned STAT_ADDR  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acq_req,
    input  logic              rel_req,
    output logic              busy,
    output logic              done,
    output logic [1:0]        result,
    output logic              reg_req,
    output logic              reg_we,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [7:0]        reg_wdata,
    input  logic              reg_ack,
    input  logic              reg_err,
    input  logic [7:0]        reg_rdata
);
    localparam int unsigned SHORT_CYC = SHORT_US * CLK_PER_US;
    localparam int unsigned LONG_CYC  = LONG_US  * CLK_PER_US;
    localparam int unsigned YIELD_CYC = YIELD_US * CLK_PER_US;
    localparam int unsigned SOFT_CYC  = SOFT_US  * CLK_PER_US;
    localparam int unsigned HARD_CYC  = HARD_US  * CLK_PER_US;
    localparam int unsigned MID_MAX   = (LONG_CYC > YIELD_CYC) ? LONG_CYC : YIELD_CYC;
    localparam int unsigned DLY_MAX   = (SHORT_CYC > MID_MAX) ? SHORT_CYC : MID_MAX;
    localparam int unsigned TW        = $clog2(DLY_MAX + 1);

    typedef struct packed {
        state_e     state;
        logic       is_acq;
        logic [7:0] ctl;
        logic [7:0] wdata;
        after_e     after;
        delay_e     dly;
        logic       done;
        result_e    result;
    } seq_t;

    seq_t s_d, s_q;

    logic          start, soft_hit, hard_hit;
    logic          tmr_load, tmr_expired;
    logic [TW-1:0] dly_val;
    logic [7:0]    dec_in;
    logic          dec_off, dec_own, dec_dirty;
    logic [7:0]    dec_take, dec_force, dec_claim, dec_clean, dec_offc;

    assign dec_in = (s_q.state == ST_RD_CTL) ? reg_rdata : s_q.ctl;

    bcs_ctl_decode u_dec (
        .ctl      (dec_in),
        .bus_off  (dec_off),
        .owned    (dec_own),
        .dirty    (dec_dirty),
        .take_cmd (dec_take),
        .force_cmd(dec_force),
        .claim_cmd(dec_claim),
        .clean_cmd(dec_clean),
        .off_cmd  (dec_offc)
    );

    bcs_deadline #(.SOFT_CYC(SOFT_CYC), .HARD_CYC(HARD_CYC)) u_deadline (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .soft_hit(soft_hit),
        .hard_hit(hard_hit)
    );

    bcs_retry_timer #(.MAX_CYC(DLY_MAX)) u_retry (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(dly_val),
        .expired (tmr_expired)
    );

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        start    = 1'b0;
        case (s_q.state)
            ST_IDLE: begin
                if (acq_req) begin
                    s_d.is_acq = 1'b1;
                    s_d.state  = ST_RD_CTL;
                    start      = 1'b1;
                end else if (rel_req) begin
                    s_d.is_acq = 1'b0;
                    s_d.state  = ST_RD_CTL;
                end
            end
            ST_RD_CTL: begin
                if (reg_ack) begin
                    s_d.ctl = reg_rdata;
                    if (reg_err) begin
                        s_d.state = ST_IDLE; s_d.done = 1'b1; s_d.result = RES_ERROR;
                    end else if (!s_q.is_acq) begin
                        if (!dec_off && dec_own) begin
                            s_d.wdata = dec_offc; s_d.after = AFT_REL; s_d.state = ST_WR;
                        end else begin
                            s_d.state = ST_IDLE; s_d.done = 1'b1; s_d.result = RES_RELEASED;
                        end
                    end else if (dec_off) begin
                        s_d.state = ST_RD_STAT;
                    end else if (dec_own) begin
                        if (dec_dirty) begin
                            s_d.wdata = dec_clean; s_d.after = AFT_ACQ; s_d.state = ST_WR;
                        end else begin
                            s_d.state = ST_IDLE; s_d.done = 1'b1; s_d.result = RES_ACQUIRED;
                        end
                    end else begin
                        s_d.dly = DLY_LONG;
                        if (soft_hit) begin
                            s_d.wdata = dec_force; s_d.after = AFT_WAIT; s_d.state = ST_WR;
                        end else if (!reg_rdata[C_CLAIM]) begin
                            s_d.wdata = dec_claim; s_d.after = AFT_WAIT; s_d.state = ST_WR;
                        end else begin
                            s_d.state = ST_WAIT;
                        end
                    end
                end
            end
            ST_RD_STAT: begin
                if (reg_ack) begin
                    if (reg_err) begin
                        s_d.state = ST_IDLE; s_d.done = 1'b1; s_d.result = RES_ERROR;
                    end else if (!reg_rdata[S_PEER_ASK] || soft_hit) begin
                        s_d.dly = DLY_SHORT; s_d.wdata = dec_take;
                        s_d.after = AFT_WAIT; s_d.state = ST_WR;
                    end else begin
                        s_d.dly = DLY_YIELD; s_d.state = ST_WAIT;
                    end
                end
            end
            ST_WR: begin
                if (reg_ack) begin
                    case (s_q.after)
                        AFT_WAIT: s_d.state = ST_WAIT;
                        AFT_ACQ: begin
                            s_d.state = ST_IDLE; s_d.done = 1'b1; s_d.result = RES_ACQUIRED;
                        end
                        default: begin
                            s_d.state = ST_IDLE; s_d.done = 1'b1; s_d.result = RES_RELEASED;
                        end
                    endcase
                end
            end
            ST_WAIT: begin
                if (tmr_expired) begin
                    if (hard_hit) begin
                        s_d.state = ST_IDLE; s_d.done = 1'b1; s_d.result = RES_TIMEOUT;
                    end else begin
                        s_d.state = ST_RD_CTL;
                    end
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_comb begin
        tmr_load = (s_d.state == ST_WAIT) && (s_q.state != ST_WAIT);
        case (s_d.dly)
            DLY_SHORT: dly_val = TW'(SHORT_CYC);
            DLY_LONG:  dly_val = TW'(LONG_CYC);
            default:   dly_val = TW'(YIELD_CYC);
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{state: ST_IDLE, is_acq: 1'b0, ctl: 8'h00, wdata: 8'h00,
                     after: AFT_WAIT, dly: DLY_SHORT, done: 1'b0, result: RES_ACQUIRED};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = (s_q.state != ST_IDLE);
    assign done      = s_q.done;
    assign result    = s_q.result;
    assign reg_req   = (s_q.state == ST_RD_CTL) || (s_q.state == ST_RD_STAT) || (s_q.state == ST_WR);
    assign reg_we    = (s_q.state == ST_WR);
    assign reg_addr  = (s_q.state == ST_RD_STAT) ? ADDR_W'(STAT_ADDR) : ADDR_W'(CTL_ADDR);
    assign reg_wdata = s_q.wdata;

    assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_ack) |=> (reg_req && $stable(reg_addr) && $stable(reg_we) && $stable(reg_wdata)));

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_first_read_ctl_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (reg_req && !reg_we && reg_addr == ADDR_W'(CTL_ADDR)));

    assert_timeout_after_hard_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == RES_TIMEOUT) |-> hard_hit);

    assert_err_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && reg_ack && reg_err && !reg_we) |=> !busy);
endmodule

// File: tb/bus_claim_seq_tb.sv
module bus_claim_seq_tb;
    localparam int CPU = 1, SH = 3, LG = 12, YD = 24, SF = 150, HD = 300;
    localparam int SHORT_C = SH * CPU, LONG_C = LG * CPU, YIELD_C = YD * CPU;
    localparam int SOFT_C = SF * CPU, HARD_C = HD * CPU;
    localparam int SLACK = 24;

    logic clk = 1'b0, rst_n = 1'b0;
    logic acq_req = 1'b0, rel_req = 1'b0;
    logic busy, done, reg_req, reg_we, reg_ack, reg_err;
    logic [1:0] result;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;

    always #5 clk = ~clk;

    bus_claim_seq #(.CLK_PER_US(CPU), .SHORT_US(SH), .LONG_US(LG), .YIELD_US(YD),
                    .SOFT_US(SF), .HARD_US(HD)) u_dut (
        .clk(clk), .rst_n(rst_n), .acq_req(acq_req), .rel_req(rel_req),
        .busy(busy), .done(done), .result(result),
        .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_ack(reg_ack), .reg_err(reg_err), .reg_rdata(reg_rdata));

    int checks = 0, errors = 0, cyc = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- selector model ----------------
    logic [7:0] ctl_m = 8'h00, stat_m = 8'h00, preset_val = 8'h00, err_addr = 8'h00;
    logic preset_go = 1'b0, err_en = 1'b0, ack_q = 1'b0;
    int   mode = 0;   // 0 store, 1 grant, 2 locked
    int   lat = 0, wait_c = 0, busy_cyc = 0;
    logic [7:0] wlog[$];
    int         wtime[$];
    logic [7:0] rlog[$];

    assign reg_ack   = ack_q;
    assign reg_err   = ack_q && err_en && !reg_we && (reg_addr == err_addr);
    assign reg_rdata = (reg_addr == 8'h02) ? stat_m : ctl_m;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        busy_cyc <= busy ? busy_cyc + 1 : 0;
        if (preset_go) ctl_m <= preset_val;
        if (reg_req && ack_q) begin
            if (reg_we) begin
                wlog.push_back(reg_wdata);
                wtime.push_back(busy_cyc);
                if (mode == 0) ctl_m <= reg_wdata;
                else if (mode == 1) ctl_m <= 8'h04;
            end else begin
                rlog.push_back(reg_addr);
            end
            ack_q <= 1'b0;
            wait_c <= 0;
        end else if (reg_req) begin
            if (wait_c >= lat) ack_q <= 1'b1;
            else wait_c <= wait_c + 1;
        end else begin
            ack_q <= 1'b0;
        end
    end

    // ---------------- per-clock monitor ----------------
    logic exp_busy = 1'b0, done_seen = 1'b0, prev_done = 1'b0, prev_pend = 1'b0, p_we = 1'b0;
    logic [7:0] p_addr = 8'h00, p_wd = 8'h00;
    logic [1:0] last_res = 2'b00;
    int done_cnt = 0, done_cyc = 0;

    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            if (done) begin
                exp_busy = 1'b0; done_seen = 1'b1; last_res = result;
                done_cyc = busy_cyc; done_cnt++;
            end
            chk(busy === exp_busy, "R11 busy tracking", busy, exp_busy);
            chk(!(done && prev_done), "R11 done lasts one cycle", done, 0);
            if (prev_pend)
                chk(reg_req && reg_addr == p_addr && reg_we == p_we && reg_wdata == p_wd,
                    "R12 access held until ack", {reg_req, reg_addr}, {1'b1, p_addr});
            prev_pend = reg_req && !reg_ack;
            p_addr = reg_addr; p_we = reg_we; p_wd = reg_wdata;
            prev_done = done;
        end
    end

    // ---------------- helpers ----------------
    logic [7:0] tab [0:15];
    int nibs [0:7];

    task automatic setup(input logic [7:0] c, input logic [7:0] s, input int m, input int l);
        @(negedge clk);
        preset_val = c; preset_go = 1'b1; stat_m = s; mode = m; lat = l;
        @(negedge clk);
        preset_go = 1'b0;
    endtask

    int w0, r0;
    task automatic run(input bit acq, input bit rel);
        w0 = wlog.size(); r0 = rlog.size();
        @(negedge clk);
        acq_req = acq; rel_req = rel; done_seen = 1'b0;
        @(negedge clk);
        acq_req = 1'b0; rel_req = 1'b0; exp_busy = 1'b1;
        while (!done_seen) @(negedge clk);
        done_seen = 1'b0;
    endtask

    int nw;
    initial begin
        tab = '{8'd4,8'd0,8'd1,8'd5,8'd4,8'd4,8'd5,8'd5,8'd0,8'd0,8'd1,8'd1,8'd0,8'd4,8'd5,8'd1};
        nibs = '{0,1,2,3,12,13,14,15};
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && reg_req == 0, "R11 reset state", {busy, done, reg_req}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(busy == 0 && reg_req == 0, "R11 idle after reset", {busy, reg_req}, 0);

        // bus off, partner quiet: take, then clean up
        setup(8'h00, 8'h00, 0, 0);
        run(1, 0);
        chk(last_res == 2'd0, "R3 result acquired", last_res, 0);
        chk(wlog.size() - w0 == 2, "R3 write count", wlog.size() - w0, 2);
        chk(wlog[w0] == 8'h84, "R3 take command", wlog[w0], 8'h84);
        chk(wlog[w0+1] == 8'h04, "R5 cleanup write", wlog[w0+1], 8'h04);
        chk(rlog.size() - r0 == 3 && rlog[r0] == 8'h01 && rlog[r0+1] == 8'h02 && rlog[r0+2] == 8'h01,
            "R1 read order ctl,stat,ctl", rlog.size() - r0, 3);

        // already held and on, clean
        setup(8'h04, 8'h00, 0, 0);
        run(1, 0);
        chk(last_res == 2'd0 && wlog.size() == w0, "R5 held bus no write", wlog.size() - w0, 0);
        chk(rlog.size() - r0 == 1, "R1 status not read when bus on", rlog.size() - r0, 1);

        // held with both bits of ownership pair set, reset flag set
        setup(8'h17, 8'h00, 0, 1);
        run(1, 0);
        chk(wlog.size() - w0 == 1 && wlog[w0] == 8'h07, "R5 clear reset flag", wlog[w0], 8'h07);
        chk(last_res == 2'd0, "R2 pair 11 owns", last_res, 0);

        // partner owns: request once, force after soft deadline
        setup(8'h05, 8'h00, 0, 2);
        run(1, 0);
        nw = wlog.size() - w0;
        chk(nw == 3, "R6 single request write", nw, 3);
        chk(wlog[w0] == 8'h85, "R6 request command", wlog[w0], 8'h85);
        chk(wlog[w0+1] == 8'h94, "R7 forced take command", wlog[w0+1], 8'h94);
        chk(wtime[w0+1] >= SOFT_C && wtime[w0+1] <= SOFT_C + LONG_C + SLACK,
            "R7 forced take timing", wtime[w0+1], SOFT_C);
        chk(last_res == 2'd0, "R7 result acquired", last_res, 0);

        // bus off, partner asked: wait until soft deadline
        setup(8'h00, 8'h80, 0, 0);
        run(1, 0);
        chk(wtime[w0] >= SOFT_C && wtime[w0] <= SOFT_C + YIELD_C + SLACK,
            "R4 yield until soft deadline", wtime[w0], SOFT_C);
        chk(wlog[w0] == 8'h84, "R3 take after soft deadline", wlog[w0], 8'h84);

        // partner never lets go: timeout
        setup(8'h05, 8'h00, 2, 0);
        run(1, 0);
        chk(last_res == 2'd1, "R8 timeout result", last_res, 1);
        chk(done_cyc >= HARD_C && done_cyc <= HARD_C + LONG_C + SLACK, "R8 timeout timing", done_cyc, HARD_C);

        // releases
        setup(8'h98, 8'h00, 0, 0);
        run(0, 1);
        chk(last_res == 2'd3 && wlog.size() - w0 == 1 && wlog[w0] == 8'h04, "R9 release write", wlog[w0], 8'h04);
        setup(8'h05, 8'h00, 0, 0);
        run(0, 1);
        chk(last_res == 2'd3 && wlog.size() == w0, "R9 release partner bus no write", wlog.size() - w0, 0);
        setup(8'h00, 8'h00, 0, 0);
        run(0, 1);
        chk(wlog.size() == w0 && ctl_m == 8'h00, "R9 release off bus no write", ctl_m, 0);

        // error responses
        setup(8'h00, 8'h00, 0, 0);
        err_en = 1'b1; err_addr = 8'h01;
        run(1, 0);
        chk(last_res == 2'd2 && wlog.size() == w0 && rlog.size() - r0 == 1, "R10 ctl read error", last_res, 2);
        err_addr = 8'h02;
        run(1, 0);
        chk(last_res == 2'd2 && wlog.size() == w0 && rlog.size() - r0 == 2, "R10 stat read error", last_res, 2);
        err_en = 1'b0;

        // table sweep over bus-off nibbles
        foreach (nibs[i]) begin
            setup(8'(nibs[i]), 8'h00, 1, 0);
            run(1, 0);
            chk(wlog[w0] == (tab[nibs[i]] | 8'h80), "R3 table lookup", wlog[w0], tab[nibs[i]] | 8'h80);
        end

        // both requests: acquire wins; requests during busy ignored
        setup(8'h04, 8'h00, 0, 4);
        run(1, 1);
        chk(last_res == 2'd0, "R11 acquire wins", last_res, 0);
        setup(8'h05, 8'h00, 0, 0);
        w0 = wlog.size();
        @(negedge clk); acq_req = 1'b1; done_seen = 1'b0;
        @(negedge clk); acq_req = 1'b0; exp_busy = 1'b1;
        repeat (20) @(negedge clk);
        acq_req = 1'b1; rel_req = 1'b1;
        @(negedge clk); acq_req = 1'b0; rel_req = 1'b0;
        while (!done_seen) @(negedge clk);
        nw = done_cnt;
        repeat (8) @(negedge clk);
        chk(done_cnt == nw && !busy, "R11 requests ignored while busy", done_cnt, nw);
        chk(last_res == 2'd0, "R11 original acquire completes", last_res, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog R11 actual=%0d expected=%0d", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule